// File: doc/BRIEF.md
# Asynchronous Serial Port with Handshake Lines

This block is a full-duplex asynchronous serial port that hangs off a 16-bit processor I/O bus. Software sees four word registers in a small window of I/O space: a data register (write to send, read to receive), a control register, a status register and a baud divisor. Each serial bit lasts sixteen ticks of an internal baud tick, and that tick comes from the system clock divided by the programmed divisor. This gives a bit rate of f_clk / (16 × divisor).

The status register reports receive data-ready, framing error and transmitter-empty. Its low four bits are general-purpose I/O lines that serve as modem handshake signals: line 0 is data-terminal-ready, line 1 is data-set-ready, line 2 is request-to-send and line 3 is clear-to-send. A queued byte only goes out on the wire once lines 0 and 2 both read high.

Receive and transmit share one level interrupt. A handler tells the two causes apart by testing data-ready first and transmitter-empty second.

Top module: `sport_hs_uart`

## Requirements
- R1: The four registers decode at ADDR_BASE+0 (data), +1 (control), +2 (status) and +3 (divisor); only addresses whose upper 14 bits match ADDR_BASE respond. The divisor reads back the 16-bit value written to it.
- R2: A serial bit lasts 16 × D clock cycles, where D is the divisor value. A divisor of 0 behaves as 1.
- R3: A transmitted frame has the following shape:
  - The idle line is high.
  - One low start bit.
  - Eight data bits, least significant first.
  - High stop bits: one when control bit 6 is 0, two when it is 1.
  - Start to end of the final stop bit spans 160 × D cycles with one stop bit and 176 × D cycles with two.
- R4: Status bit 12 (transmitter-empty) behaves as follows:
  - It is 1 out of reset.
  - A write to the data register clears it.
  - It sets again when the last stop bit ends.
  - A data write made while it is 0 is ignored, and that byte is never sent.
- R5: A pending byte does not start its frame until I/O lines 0 and 2 both read 1. While they do not, txd stays high and status bit 12 stays 0.
- R6: Reception works as follows:
  - A falling edge on rxd starts the receiver.
  - Each bit is taken at the 8th of its 16 samples.
  - Mid-way through the stop bit, status bit 8 (data-ready) sets and the byte appears in bits 7:0 of a data-register read.
  - That read clears bit 8.
- R7: Status bit 9 (framing error) is loaded at each received byte: 1 if the stop bit sampled low, 0 otherwise.
- R8: The four I/O lines are set up as follows:
  - Control bits 3:0 choose direction per line (1 = output, mirrored on gpio_oe).
  - A write to status bits 3:0 sets the output values.
  - Status bits 3:0 read the line level: the output value on output lines, gpio_in on input lines.
- R9: irq is high exactly while (data-ready AND control bit 4) OR (transmitter-empty AND control bit 5).
- R10: While control bit 7 is 1, the following hold, and the byte dropped this way is never sent:
  - both shifters are held idle;
  - txd is high;
  - data-ready and framing error are cleared;
  - a pending transmit byte is dropped, so status bit 12 reads 1.
- R11: After reset the following hold:
  - control is 0;
  - the divisor is 1;
  - txd is 1 and irq is 0;
  - the status register reads 0x1000 when gpio_in is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined receive/transmit interrupt, level |
| gpio_in | input | 4 | Handshake line inputs |
| gpio_out | output | 4 | Handshake line output values |
| gpio_oe | output | 4 | Handshake line output enables |

## Verification
The bench targets the following corner cases:
- **Frame length under each stop-bit setting and under divisor 0.** A baud generator that let divisor 0 wrap would stretch the frame by a factor of thousands. One that miscounted the stop bits would end transmitter-empty a bit early or late.
- **A second data write issued while the first byte is still in flight.** A design that accepted it would put an unexpected frame on the wire, or a corrupted first one.
- **Frames held back by a low request-to-send line.** A design that ignored the handshake would start the frame at once.
- **Framing error on a low stop bit, and its clearing by the next good byte.** A design without this clearing would leave the error stuck.
- **Interrupt level following each enable.**
- **Soft reset dropping a pending byte.** A design without the drop would send a stale frame once the handshake came up.

// File: rtl/sport_pkg.sv
// Shared constants and types for the handshake serial port.
// Assumes a 16-bit I/O bus with word addressing of the register window.
package sport_pkg;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_state_e;

    // Register offsets inside the four-word window
    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_CTRL = 2'd1;
    localparam logic [1:0] OFS_STAT = 2'd2;
    localparam logic [1:0] OFS_DIV  = 2'd3;

    // Control bit positions
    localparam int CB_RXIE     = 4;
    localparam int CB_TXIE     = 5;
    localparam int CB_TWO_STOP = 6;
    localparam int CB_SRST     = 7;

    // Status bit positions
    localparam int SB_READY   = 8;
    localparam int SB_FERR    = 9;
    localparam int SB_TXEMPTY = 12;

endpackage

// File: rtl/sport_baud.sv
// Baud tick generator: emits a one-cycle tick every DIV clocks (DIV of 0 acts as 1).
// Assumes the divisor may change at any time; the counter then wraps at the new limit.
module sport_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // Last count value before a tick
    always_comb limit = (divisor == '0) ? '0 : divisor - 1'b1;

    assign tick = (cnt_q >= limit);

    // Free-running divider counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // With divisor above 1, ticks are never back to back
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || divisor <= 1));

endmodule

// File: rtl/sport_tx.sv
// Transmit shifter: holds one byte, starts a frame on a baud tick once the
// handshake is good, sends start, data LSB first, then one or two stop bits.
// Assumes tick is a single-cycle pulse at OVS times the bit rate.
module sport_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              two_stop,
    input  logic              hs_ok,
    output logic              txd,
    output logic              busy
);
    import sport_pkg::*;

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);

    line_state_e       st_q;
    logic [CNT_W-1:0]  ovs_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q;
    logic              stop2_q;
    logic              bit_end;

    assign bit_end = tick && (ovs_q == CNT_W'(OVS - 1));

    // Frame sequencer and shift register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q    <= LN_IDLE;
            ovs_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            stop2_q <= 1'b0;
            busy    <= 1'b0;
        end else begin
            if (load && !busy) begin
                sh_q <= load_data;
                busy <= 1'b1;
            end
            if (st_q != LN_IDLE && tick) ovs_q <= ovs_q + 1'b1;
            case (st_q)
                LN_IDLE: if (busy && hs_ok && tick) begin
                    st_q  <= LN_START;
                    ovs_q <= '0;
                end
                LN_START: if (bit_end) begin
                    st_q  <= LN_DATA;
                    idx_q <= '0;
                end
                LN_DATA: if (bit_end) begin
                    sh_q  <= sh_q >> 1;
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(DATA_W - 1)) begin
                        st_q    <= LN_STOP;
                        stop2_q <= two_stop;
                    end
                end
                default: if (bit_end) begin
                    if (stop2_q) stop2_q <= 1'b0;
                    else begin
                        st_q <= LN_IDLE;
                        busy <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Line level from the current frame position
    always_comb begin
        case (st_q)
            LN_START: txd = 1'b0;
            LN_DATA:  txd = sh_q[0];
            default:  txd = 1'b1;
        endcase
    end

    assert_start_needs_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(txd) && st_q == LN_START) |-> $past(hs_ok));

    assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && busy && st_q == LN_IDLE && !clr) |=> $stable(sh_q));

endmodule

// File: rtl/sport_rx.sv
// Receive shifter: waits for a falling edge, samples each bit at the middle
// of its OVS ticks, and pulses done mid-way through the stop bit.
// Assumes rxd is asynchronous; it is synchronised here with two flops.
module sport_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              stop_bad
);
    import sport_pkg::*;

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);

    line_state_e       st_q;
    logic [2:0]        sync_q;
    logic [CNT_W-1:0]  ovs_q;
    logic [IDX_W-1:0]  idx_q;
    logic              mid;
    logic              bit_end;
    logic              rx_s;

    assign rx_s    = sync_q[1];
    assign mid     = tick && (ovs_q == CNT_W'(OVS / 2 - 1));
    assign bit_end = tick && (ovs_q == CNT_W'(OVS - 1));

    // Input synchroniser plus edge history
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[1:0], rxd};
    end

    // Receive sequencer
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q     <= LN_IDLE;
            ovs_q    <= '0;
            idx_q    <= '0;
            data     <= '0;
            done     <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st_q != LN_IDLE && tick) ovs_q <= ovs_q + 1'b1;
            case (st_q)
                LN_IDLE: if (sync_q[2] && !rx_s) begin
                    st_q  <= LN_START;
                    ovs_q <= '0;
                end
                LN_START: begin
                    if (mid && rx_s) st_q <= LN_IDLE;
                    else if (bit_end) begin
                        st_q  <= LN_DATA;
                        idx_q <= '0;
                    end
                end
                LN_DATA: begin
                    if (mid) data <= {rx_s, data[DATA_W-1:1]};
                    if (bit_end) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == IDX_W'(DATA_W - 1)) st_q <= LN_STOP;
                    end
                end
                default: if (mid) begin
                    done     <= 1'b1;
                    stop_bad <= !rx_s;
                    st_q     <= LN_IDLE;
                end
            endcase
        end
    end

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sport_hs_uart.sv
// Top of the handshake serial port: bus register decode, handshake I/O lines,
// status flags and the combined interrupt.
// Assumes single-cycle bus strobes; read data is combinational in the strobe cycle.
module sport_hs_uart #(
    parameter logic [15:0] ADDR_BASE = 16'hFFF4,
    parameter int          DIV_W     = 16,
    parameter int          N_IO      = 4,
    parameter int          DATA_W    = 8,
    parameter int          OVS       = 16,
    parameter int          DIV_RESET = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     bus_addr,
    input  logic [15:0]     bus_wdata,
    input  logic            bus_wr,
    input  logic            bus_rd,
    output logic [15:0]     bus_rdata,
    input  logic            rxd,
    output logic            txd,
    output logic            irq,
    input  logic [N_IO-1:0] gpio_in,
    output logic [N_IO-1:0] gpio_out,
    output logic [N_IO-1:0] gpio_oe
);
    import sport_pkg::*;

    logic [7:0]        ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [N_IO-1:0]   gpo_q;
    logic [N_IO-1:0]   lines;
    logic [DATA_W-1:0] rx_byte;
    logic              rdy_q, ferr_q;
    logic              sel, wr_data, wr_ctrl, wr_stat, wr_div, rd_data;
    logic              tick, tx_busy, rx_done, rx_bad, soft_rst, hs_ok;

    assign sel      = (bus_addr[15:2] == ADDR_BASE[15:2]);
    assign wr_data  = bus_wr && sel && bus_addr[1:0] == OFS_DATA;
    assign wr_ctrl  = bus_wr && sel && bus_addr[1:0] == OFS_CTRL;
    assign wr_stat  = bus_wr && sel && bus_addr[1:0] == OFS_STAT;
    assign wr_div   = bus_wr && sel && bus_addr[1:0] == OFS_DIV;
    assign rd_data  = bus_rd && sel && bus_addr[1:0] == OFS_DATA;
    assign soft_rst = ctrl_q[CB_SRST];
    assign gpio_oe  = ctrl_q[N_IO-1:0];
    assign gpio_out = gpo_q;
    assign hs_ok    = lines[0] && lines[2];

    // Per-line level seen by software: driven value or external input
    for (genvar g = 0; g < N_IO; g++) begin : g_line
        assign lines[g] = gpio_oe[g] ? gpo_q[g] : gpio_in[g];
    end

    // Control, divisor and output-value registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= DIV_W'(DIV_RESET);
            gpo_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[7:0];
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
            if (wr_stat) gpo_q  <= bus_wdata[N_IO-1:0];
        end
    end

    // Receive flags: set on a new byte, ready cleared by a data read
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            rdy_q  <= 1'b0;
            ferr_q <= 1'b0;
        end else if (rx_done) begin
            rdy_q  <= 1'b1;
            ferr_q <= rx_bad;
        end else if (rd_data) begin
            rdy_q  <= 1'b0;
        end
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && sel) begin
            case (bus_addr[1:0])
                OFS_DATA: bus_rdata[DATA_W-1:0] = rx_byte;
                OFS_CTRL: bus_rdata[7:0]        = ctrl_q;
                OFS_STAT: begin
                    bus_rdata[N_IO-1:0]  = lines;
                    bus_rdata[SB_READY]  = rdy_q;
                    bus_rdata[SB_FERR]   = ferr_q;
                    bus_rdata[SB_TXEMPTY] = !tx_busy;
                end
                default:  bus_rdata[DIV_W-1:0]  = div_q;
            endcase
        end
    end

    assign irq = (rdy_q && ctrl_q[CB_RXIE]) || (!tx_busy && ctrl_q[CB_TXIE]);

    sport_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .divisor(div_q), .tick(tick)
    );

    sport_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .tick(tick),
        .load(wr_data), .load_data(bus_wdata[DATA_W-1:0]),
        .two_stop(ctrl_q[CB_TWO_STOP]), .hs_ok(hs_ok),
        .txd(txd), .busy(tx_busy)
    );

    sport_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .tick(tick), .rxd(rxd),
        .done(rx_done), .data(rx_byte), .stop_bad(rx_bad)
    );

    assert_read_clears_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_done) |=> !rdy_q);

    assert_soft_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (txd && !rdy_q && !ferr_q));

    assert_write_clears_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !soft_rst) |=> tx_busy);

endmodule

// File: tb/sport_hs_uart_test.sv
module sport_hs_uart_test;
    localparam int CLK_P = 10;
    localparam logic [15:0] A_DATA = 16'hFFF4;
    localparam logic [15:0] A_CTRL = 16'hFFF5;
    localparam logic [15:0] A_STAT = 16'hFFF6;
    localparam logic [15:0] A_DIV  = 16'hFFF7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic        rxd = 1'b1, txd, irq;
    logic [3:0]  gpio_in = '0, gpio_out, gpio_oe;

    int checks = 0, fails = 0, frames = 0, cur_div = 2;
    logic [7:0] tx_exp[$];
    logic [7:0] rx_exp[$];

    sport_hs_uart uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq(irq),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Driver: queue the expected byte, then write it to the port
    task automatic send_tx(input logic [7:0] b);
        tx_exp.push_back(b);
        bus_write(A_DATA, {8'h00, b});
    endtask

    task automatic wait_tx_empty();
        logic [15:0] s;
        for (int i = 0; i < 2000; i++) begin
            bus_read(A_STAT, s);
            if (s[12]) return;
        end
        check(1'b0, "R4 transmitter-empty never returned", 0, 1);
    endtask

    // Send a byte and return cycles from start edge to transmitter-empty
    task automatic timed_frame(input logic [7:0] b, output int cyc);
        logic [15:0] s;
        time t0;
        send_tx(b);
        @(negedge txd);
        t0 = $time;
        s = '0;
        while (!s[12]) bus_read(A_STAT, s);
        cyc = int'(($time - t0) / CLK_P);
    endtask

    // Serial driver for the receive line; queues the byte it sends
    task automatic send_rx(input logic [7:0] b, input bit stop_ok);
        int bt;
        bt = 16 * cur_div;
        rx_exp.push_back(b);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bt) @(negedge clk);
        end
        rxd = stop_ok;
        repeat (bt) @(negedge clk);
        rxd = 1'b1;
        repeat (bt) @(negedge clk);
    endtask

    task automatic rx_read(input string tag);
        logic [15:0] d;
        logic [7:0] e;
        bus_read(A_DATA, d);
        e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 8'hxx;
        check(d[7:0] === e, tag, d[7:0], e);
    endtask

    // Monitor: decode each frame on txd and compare with the queue
    initial begin
        logic [7:0] got;
        logic [7:0] e;
        forever begin
            @(negedge txd);
            repeat (8 * cur_div) @(posedge clk);
            #1 check(txd == 1'b0, "R3 start bit low", txd, 0);
            for (int i = 0; i < 8; i++) begin
                repeat (16 * cur_div) @(posedge clk);
                #1 got[i] = txd;
            end
            repeat (16 * cur_div) @(posedge clk);
            #1 check(txd == 1'b1, "R3 stop bit high", txd, 1);
            frames++;
            if (tx_exp.size() == 0) check(1'b0, "R4 unexpected frame", got, 0);
            else begin
                e = tx_exp.pop_front();
                check(got == e, "R3 frame data", got, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] s;
        int cyc, f0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        bus_read(A_STAT, s);
        check(s == 16'h1000, "R11 status after reset", s, 16'h1000);
        check(txd == 1'b1, "R11 txd idle", txd, 1);
        check(irq == 1'b0, "R11 irq low", irq, 0);
        bus_read(A_DIV, s);
        check(s == 16'd1, "R11 divisor reset", s, 1);
        bus_read(16'hFFF0, s);
        check(s == 16'h0000, "R1 outside window reads zero", s, 0);

        // R1 divisor, R8 handshake lines
        bus_write(A_DIV, 16'd2);
        bus_read(A_DIV, s);
        check(s == 16'd2, "R1 divisor readback", s, 2);
        bus_write(A_CTRL, 16'h0005);
        bus_write(A_STAT, 16'h0005);
        check(gpio_oe == 4'h5 && gpio_out == 4'h5, "R8 direction and values", {gpio_oe, gpio_out}, 8'h55);
        gpio_in = 4'b1010;
        bus_read(A_STAT, s);
        check(s[3:0] == 4'hF, "R8 mixed line read", s[3:0], 4'hF);
        gpio_in = 4'b0000;
        bus_read(A_STAT, s);
        check(s[3:0] == 4'h5, "R8 inputs low", s[3:0], 4'h5);

        // R4 write clears empty; R3 frame patterns
        send_tx(8'hA5);
        bus_read(A_STAT, s);
        check(s[12] == 1'b0, "R4 empty cleared by write", s[12], 0);
        wait_tx_empty();
        send_tx(8'h00); wait_tx_empty();
        send_tx(8'hFF); wait_tx_empty();

        // R2/R3 frame length, one stop bit
        timed_frame(8'h3C, cyc);
        check(cyc >= 318 && cyc <= 322, "R2 one-stop frame cycles", cyc, 320);

        // R4 write while busy ignored
        send_tx(8'h11);
        bus_write(A_DATA, 16'h0022);
        wait_tx_empty();
        repeat (400) @(negedge clk);

        // R3 two stop bits
        bus_write(A_CTRL, 16'h0045);
        timed_frame(8'h5A, cyc);
        check(cyc >= 350 && cyc <= 354, "R3 two-stop frame cycles", cyc, 352);
        bus_write(A_CTRL, 16'h0005);
        repeat (40) @(negedge clk);

        // R2 divisor zero behaves as one
        bus_write(A_DIV, 16'd0);
        cur_div = 1;
        timed_frame(8'h96, cyc);
        check(cyc >= 158 && cyc <= 162, "R2 divisor zero frame cycles", cyc, 160);
        repeat (40) @(negedge clk);
        bus_write(A_DIV, 16'd2);
        cur_div = 2;

        // R5 handshake gating
        bus_write(A_STAT, 16'h0001);
        f0 = frames;
        send_tx(8'hC3);
        repeat (600) @(negedge clk);
        check(frames == f0 && txd == 1'b1, "R5 held without RTS", frames, f0);
        bus_read(A_STAT, s);
        check(s[12] == 1'b0, "R5 empty stays low while held", s[12], 0);
        bus_write(A_STAT, 16'h0005);
        wait_tx_empty();
        repeat (40) @(negedge clk);
        check(frames == f0 + 1, "R5 frame after handshake", frames, f0 + 1);

        // R6 reception
        send_rx(8'h5A, 1'b1);
        bus_read(A_STAT, s);
        check(s[8] == 1'b1 && s[9] == 1'b0, "R6 ready set", s[9:8], 1);
        rx_read("R6 received byte 5A");
        bus_read(A_STAT, s);
        check(s[8] == 1'b0, "R6 ready cleared by read", s[8], 0);
        send_rx(8'h81, 1'b1);
        rx_read("R6 received byte 81");

        // R7 framing error
        send_rx(8'h33, 1'b0);
        bus_read(A_STAT, s);
        check(s[9] == 1'b1, "R7 framing error set", s[9], 1);
        rx_read("R7 byte with bad stop");
        send_rx(8'hC7, 1'b1);
        bus_read(A_STAT, s);
        check(s[9] == 1'b0, "R7 framing error cleared", s[9], 0);
        rx_read("R7 next good byte");

        // R9 interrupt
        bus_write(A_CTRL, 16'h0015);
        check(irq == 1'b0, "R9 rx enable without data", irq, 0);
        send_rx(8'h77, 1'b1);
        check(irq == 1'b1, "R9 irq on data-ready", irq, 1);
        rx_read("R9 byte 77");
        check(irq == 1'b0, "R9 irq drops after read", irq, 0);
        bus_write(A_CTRL, 16'h0025);
        check(irq == 1'b1, "R9 irq on tx empty", irq, 1);
        send_tx(8'h44);
        check(irq == 1'b0, "R9 irq low while sending", irq, 0);
        wait_tx_empty();
        check(irq == 1'b1, "R9 irq after frame", irq, 1);
        bus_write(A_CTRL, 16'h0005);
        repeat (40) @(negedge clk);

        // R10 soft reset
        send_rx(8'h99, 1'b1);
        bus_write(A_STAT, 16'h0001);
        f0 = frames;
        bus_write(A_DATA, 16'h00EE);
        bus_write(A_CTRL, 16'h0085);
        bus_read(A_STAT, s);
        check(s[8] == 1'b0 && s[12] == 1'b1, "R10 flags under soft reset", s, 16'h1001);
        check(txd == 1'b1, "R10 txd high", txd, 1);
        bus_write(A_CTRL, 16'h0005);
        bus_write(A_STAT, 16'h0005);
        repeat (600) @(negedge clk);
        check(frames == f0, "R10 dropped byte not sent", frames, f0);
        void'(rx_exp.pop_front());

        check(tx_exp.size() == 0, "R3 all expected frames seen", tx_exp.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule